// File: doc/BRIEF.md
# Asynchronous SRAM Bus Timing Checker

This block watches the pins of an asynchronous static RAM bus from the host side. It samples them on a system clock and reports protocol and timing faults. It looks at the two chip enables, the write strobe, the output enable and the address, plus one signal from the host that says whether the host is driving the data lines. Every interval it measures is a count of sample clocks. Each minimum it compares against is a parameter, so the same block serves a faster or a slower memory grade once the limits are recomputed for the sample rate.

A write exists only while both enables are active and the write strobe is low. Whichever of the three strobes releases first closes the write. At that closing sample the checker looks back over four intervals: the overlap itself, the select time, the address stability and the host data drive. Outside writes it watches for two faults. One is an address that moves while the write strobe stays low. The other is the host driving the data lines while the memory is driving them too. Each fault sets its own sticky flag, adds to a saturating count and leaves its code in a register until the next clear.

Top module: `sram_bus_chk`

## Requirements
- R1: After reset the flags, the counter and the code are zero. The bus history is taken as idle: enables inactive, write strobe high, address 0 and host not driving.
- R2: A write window is every sample with `ce1_n_i` low, `ce2_i` high and `we_n_i` low. It ends at the first sample where any of the three is inactive. A window shorter than `WP_MIN` samples sets flag bit 0 and code 1.
- R3: At the end of a write, the select run is counted as the consecutive samples with both enables active, up to the last write sample. This times the select from the later of the two enable edges. A run below `CW_MIN` sets flag bit 1 and code 2.
- R4: At the end of a write, the address run is counted as the consecutive samples with an unchanged address, up to the last write sample. A run below `AW_MIN` sets flag bit 2 and code 3.
- R5: At the end of a write, the drive run is counted as the consecutive samples with `host_drv_i` high, up to the last write sample. A run below `DW_MIN` sets flag bit 3 and code 4.
- R6: An address difference between two consecutive samples that both have `we_n_i` low sets flag bit 4 and code 5, whatever the enables are.
- R7: `host_drv_i` high in a sample with both enables active, `we_n_i` high and `oe_n_i` low sets flag bit 5 and code 6.
- R8: Host drive is not flagged while `we_n_i` is low, while `oe_n_i` is high, or while deselected. This holds when selection arrives in the same sample as the write strobe falls.
- R9: Flags are sticky. The code holds the most recent violation. When several violations occur in one sample, the code is the highest of their numbers.
- R10: The counter adds the number of violations found in each sample and saturates at 65535.
- R11: `clr_i` is sampled together with the pins. It zeroes the flags, the counter and the code, and it overrides any violation in the same sample.
- R12: A violation in the pins sampled at clock edge n shows on the outputs after edge n+1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Sample clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ce1_n_i | input | 1 | Chip enable, active low |
| ce2_i | input | 1 | Chip enable, active high |
| we_n_i | input | 1 | Write strobe, active low |
| oe_n_i | input | 1 | Output enable, active low |
| addr_i | input | ADDR_W | Address pins |
| host_drv_i | input | 1 | Host data driver enabled |
| clr_i | input | 1 | Synchronous clear of flags, counter and code |
| err_flags_o | output | 6 | Sticky flag per violation type |
| viol_cnt_o | output | 16 | Saturating violation count |
| viol_code_o | output | 4 | Code of the most recent violation |

## Verification
An end of write and an address move can land in the same sample. This happens when `ce2_i` drops and the address changes while `we_n_i` stays low. The bench provokes it after a two-sample write, so the short pulse and the address move fire together. It expects the counter to step by two and the code to read 5 rather than 1. A second coincidence is a clear in the same sample as host contention, which must leave everything at zero. The behavioural model rescans the sample history and is compared on every clock.

// File: rtl/sram_chk_pkg.sv
package sram_chk_pkg;
  localparam int NUM_VIOL = 6;
  localparam int CODE_W   = 4;

  // flag bit index; reported code is index + 1
  localparam int BIT_WP    = 0;
  localparam int BIT_CW    = 1;
  localparam int BIT_AW    = 2;
  localparam int BIT_DW    = 3;
  localparam int BIT_AMOVE = 4;
  localparam int BIT_FIGHT = 5;

  // run counter slots
  localparam int RUN_WR   = 0;
  localparam int RUN_SEL  = 1;
  localparam int RUN_DRV  = 2;
  localparam int RUN_ADDR = 3;
  localparam int NUM_RUN  = 4;

  typedef struct packed {
    logic ce1_n;
    logic ce2;
    logic we_n;
    logic oe_n;
    logic host_drv;
    logic clr;
  } pin_t;

  localparam pin_t PIN_IDLE = '{ce1_n: 1'b1, ce2: 1'b0, we_n: 1'b1, oe_n: 1'b1,
                                host_drv: 1'b0, clr: 1'b0};
endpackage

// File: rtl/sram_chk_sample.sv
module sram_chk_sample
  import sram_chk_pkg::*;
#(
  parameter int ADDR_W = 17
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  pin_t              pin_i,
  input  logic [ADDR_W-1:0] addr_i,
  output pin_t              cur_o,
  output logic [ADDR_W-1:0] cur_addr_o,
  output logic              prv_wr_o,
  output logic              prv_we_n_o,
  output logic [ADDR_W-1:0] prv_addr_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cur_o      <= PIN_IDLE;
      cur_addr_o <= '0;
      prv_wr_o   <= 1'b0;
      prv_we_n_o <= 1'b1;
      prv_addr_o <= '0;
    end else begin
      cur_o      <= pin_i;
      cur_addr_o <= addr_i;
      prv_wr_o   <= !cur_o.ce1_n && cur_o.ce2 && !cur_o.we_n;
      prv_we_n_o <= cur_o.we_n;
      prv_addr_o <= cur_addr_o;
    end
  end
endmodule

// File: rtl/sram_chk_run.sv
module sram_chk_run #(
  parameter int W        = 8,
  parameter bit MISS_ONE = 1'b0,
  parameter bit RST_FULL = 1'b0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         cont_i,
  output logic [W-1:0] run_o
);
  localparam logic [W-1:0] FULL = {W{1'b1}};
  localparam logic [W-1:0] MISS = MISS_ONE ? W'(1) : {W{1'b0}};
  localparam logic [W-1:0] RSTV = RST_FULL ? FULL : {W{1'b0}};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)          run_o <= RSTV;
    else if (cont_i)      run_o <= (run_o == FULL) ? FULL : run_o + W'(1);
    else                  run_o <= MISS;
  end

  // R4
  run_sat_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_o == FULL) && cont_i |=> run_o == FULL);
endmodule

// File: rtl/sram_chk_detect.sv
module sram_chk_detect
  import sram_chk_pkg::*;
#(
  parameter int CNT_W  = 8,
  parameter int WP_MIN = 4,
  parameter int CW_MIN = 6,
  parameter int AW_MIN = 6,
  parameter int DW_MIN = 3
) (
  input  logic                wr_cur_i,
  input  logic                wr_prv_i,
  input  logic                we_low_both_i,
  input  logic                addr_moved_i,
  input  logic                fight_i,
  input  logic [CNT_W-1:0]    wr_run_i,
  input  logic [CNT_W-1:0]    sel_run_i,
  input  logic [CNT_W-1:0]    addr_run_i,
  input  logic [CNT_W-1:0]    drv_run_i,
  output logic [NUM_VIOL-1:0] viol_o
);
  localparam logic [CNT_W-1:0] WP_LIM = CNT_W'(WP_MIN);
  localparam logic [CNT_W-1:0] CW_LIM = CNT_W'(CW_MIN);
  localparam logic [CNT_W-1:0] AW_LIM = CNT_W'(AW_MIN);
  localparam logic [CNT_W-1:0] DW_LIM = CNT_W'(DW_MIN);

  logic wr_end;
  assign wr_end = wr_prv_i && !wr_cur_i;

  always_comb begin
    viol_o            = '0;
    viol_o[BIT_WP]    = wr_end && (wr_run_i   < WP_LIM);
    viol_o[BIT_CW]    = wr_end && (sel_run_i  < CW_LIM);
    viol_o[BIT_AW]    = wr_end && (addr_run_i < AW_LIM);
    viol_o[BIT_DW]    = wr_end && (drv_run_i  < DW_LIM);
    viol_o[BIT_AMOVE] = we_low_both_i && addr_moved_i;
    viol_o[BIT_FIGHT] = fight_i;
  end
endmodule

// File: rtl/sram_chk_log.sv
module sram_chk_log
  import sram_chk_pkg::*;
#(
  parameter int VCNT_W = 16
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                clr_i,
  input  logic [NUM_VIOL-1:0] viol_i,
  output logic [NUM_VIOL-1:0] flags_o,
  output logic [VCNT_W-1:0]   cnt_o,
  output logic [CODE_W-1:0]   code_o
);
  logic [CODE_W-1:0] pick;
  logic [VCNT_W:0]   sum;

  always_comb begin
    pick = '0;
    for (int i = 0; i < NUM_VIOL; i++)
      if (viol_i[i]) pick = CODE_W'(i + 1);  // highest index wins
    sum = {1'b0, cnt_o} + (VCNT_W + 1)'($countones(viol_i));
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      flags_o <= '0;
      cnt_o   <= '0;
      code_o  <= '0;
    end else if (clr_i) begin
      flags_o <= '0;
      cnt_o   <= '0;
      code_o  <= '0;
    end else begin
      flags_o <= flags_o | viol_i;
      cnt_o   <= sum[VCNT_W] ? {VCNT_W{1'b1}} : sum[VCNT_W-1:0];
      if (|viol_i) code_o <= pick;
    end
  end

  // R9
  flags_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !clr_i |=> (flags_o & $past(flags_o)) == $past(flags_o));
  // R11
  clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> (flags_o == '0) && (cnt_o == '0) && (code_o == '0));
  // R10
  cnt_mono_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !clr_i |=> cnt_o >= $past(cnt_o));
endmodule

// File: rtl/sram_bus_chk.sv
module sram_bus_chk
  import sram_chk_pkg::*;
#(
  parameter int ADDR_W = 17,
  parameter int CNT_W  = 8,
  parameter int VCNT_W = 16,
  parameter int WP_MIN = 4,
  parameter int CW_MIN = 6,
  parameter int AW_MIN = 6,
  parameter int DW_MIN = 3
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                ce1_n_i,
  input  logic                ce2_i,
  input  logic                we_n_i,
  input  logic                oe_n_i,
  input  logic [ADDR_W-1:0]   addr_i,
  input  logic                host_drv_i,
  input  logic                clr_i,
  output logic [NUM_VIOL-1:0] err_flags_o,
  output logic [VCNT_W-1:0]   viol_cnt_o,
  output logic [CODE_W-1:0]   viol_code_o
);
  pin_t              pin_in, cur;
  logic [ADDR_W-1:0] cur_addr, prv_addr;
  logic              prv_wr, prv_we_n;
  logic              sel_cur, wr_cur, fight, addr_same, we_low_both;
  logic [NUM_RUN-1:0] run_cont;
  logic [CNT_W-1:0]  run_val [NUM_RUN];
  logic [NUM_VIOL-1:0] viol;

  assign pin_in = '{ce1_n: ce1_n_i, ce2: ce2_i, we_n: we_n_i, oe_n: oe_n_i,
                    host_drv: host_drv_i, clr: clr_i};

  sram_chk_sample #(.ADDR_W(ADDR_W)) u_sample (
    .clk_i, .rst_ni, .pin_i(pin_in), .addr_i,
    .cur_o(cur), .cur_addr_o(cur_addr), .prv_wr_o(prv_wr),
    .prv_we_n_o(prv_we_n), .prv_addr_o(prv_addr)
  );

  assign sel_cur     = !cur.ce1_n && cur.ce2;
  assign wr_cur      = sel_cur && !cur.we_n;
  assign fight       = sel_cur && cur.we_n && !cur.oe_n && cur.host_drv;
  assign addr_same   = (cur_addr == prv_addr);
  assign we_low_both = !cur.we_n && !prv_we_n;

  always_comb begin
    run_cont           = '0;
    run_cont[RUN_WR]   = wr_cur;
    run_cont[RUN_SEL]  = sel_cur;
    run_cont[RUN_DRV]  = cur.host_drv;
    run_cont[RUN_ADDR] = addr_same;
  end

  for (genvar gi = 0; gi < NUM_RUN; gi++) begin : g_run
    sram_chk_run #(
      .W(CNT_W), .MISS_ONE(gi == RUN_ADDR), .RST_FULL(gi == RUN_ADDR)
    ) u_run (
      .clk_i, .rst_ni, .cont_i(run_cont[gi]), .run_o(run_val[gi])
    );
  end

  sram_chk_detect #(
    .CNT_W(CNT_W), .WP_MIN(WP_MIN), .CW_MIN(CW_MIN),
    .AW_MIN(AW_MIN), .DW_MIN(DW_MIN)
  ) u_detect (
    .wr_cur_i(wr_cur), .wr_prv_i(prv_wr), .we_low_both_i(we_low_both),
    .addr_moved_i(!addr_same), .fight_i(fight),
    .wr_run_i(run_val[RUN_WR]), .sel_run_i(run_val[RUN_SEL]),
    .addr_run_i(run_val[RUN_ADDR]), .drv_run_i(run_val[RUN_DRV]),
    .viol_o(viol)
  );

  sram_chk_log #(.VCNT_W(VCNT_W)) u_log (
    .clk_i, .rst_ni, .clr_i(cur.clr), .viol_i(viol),
    .flags_o(err_flags_o), .cnt_o(viol_cnt_o), .code_o(viol_code_o)
  );

  logic [NUM_VIOL-1:0] code_1h;
  assign code_1h = (viol_code_o == '0) ? '0
                 : (NUM_VIOL'(1) << (viol_code_o - CODE_W'(1)));

  // R9
  code_flag_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|viol) && !cur.clr |=> (err_flags_o & code_1h) != '0);
  // R8
  no_fight_we_low_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cur.we_n |-> !viol[BIT_FIGHT]);
endmodule

// File: tb/sram_bus_chk_tb_top.sv
module sram_bus_chk_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 17;
  localparam int WP = 4, CW = 6, AWM = 6, DW = 3;
  localparam int WD_CYCLES = 190000;

  typedef struct {
    bit c1n; bit c2; bit wn; bit on; bit dv; bit cl; int a;
  } vec_t;

  logic clk = 1'b0, rst_n = 1'b0;
  logic ce1_n = 1'b1, ce2 = 1'b0, we_n = 1'b1, oe_n = 1'b1, hdrv = 1'b0, clr = 1'b0;
  logic [AW-1:0] addr = '0;
  logic [5:0]  flags;
  logic [15:0] vcnt;
  logic [3:0]  vcode;

  int nchk = 0, nerr = 0;
  string tag = "R1";
  bit done = 0;

  vec_t hist[$];
  bit [5:0] ef[$];
  int ec[$], ecd[$];
  bit [5:0] m_flags = '0;
  int m_cnt = 0, m_code = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  sram_bus_chk dut_i (
    .clk_i(clk), .rst_ni(rst_n), .ce1_n_i(ce1_n), .ce2_i(ce2), .we_n_i(we_n),
    .oe_n_i(oe_n), .addr_i(addr), .host_drv_i(hdrv), .clr_i(clr),
    .err_flags_o(flags), .viol_cnt_o(vcnt), .viol_code_o(vcode)
  );

  function automatic vec_t at(int j);
    vec_t v;
    if (j < 0) begin
      v.c1n = 1; v.c2 = 0; v.wn = 1; v.on = 1; v.dv = 0; v.cl = 0; v.a = 0;
      return v;
    end
    return hist[j];
  endfunction

  function automatic bit wr(vec_t v);
    return !v.c1n && v.c2 && !v.wn;
  endfunction

  // length of the run ending at sample k-1; kind 0 write, 1 select, 2 drive, 3 address
  function automatic int run_of(int kind, int k);
    int n = 0;
    int ref_a = at(k-1).a;
    for (int j = k - 1; j >= 0; j--) begin
      vec_t v = hist[j];
      bit ok;
      case (kind)
        0: ok = wr(v);
        1: ok = !v.c1n && v.c2;
        2: ok = v.dv;
        default: ok = (v.a == ref_a);
      endcase
      if (!ok) return n;
      n++;
    end
    if (kind == 3 && ref_a == 0) return 1000000;
    return n;
  endfunction

  task automatic model_push();
    int k = hist.size() - 1;
    vec_t c = at(k), p = at(k-1);
    bit [5:0] vb = '0;
    if (wr(p) && !wr(c)) begin
      if (run_of(0, k) < WP)  vb[0] = 1;
      if (run_of(1, k) < CW)  vb[1] = 1;
      if (run_of(3, k) < AWM) vb[2] = 1;
      if (run_of(2, k) < DW)  vb[3] = 1;
    end
    if (!c.wn && !p.wn && c.a != p.a) vb[4] = 1;
    if (!c.c1n && c.c2 && c.wn && !c.on && c.dv) vb[5] = 1;
    if (c.cl) begin
      m_flags = '0; m_cnt = 0; m_code = 0;
    end else begin
      m_flags |= vb;
      for (int i = 0; i < 6; i++)
        if (vb[i]) begin m_cnt++; m_code = i + 1; end
      if (m_cnt > 65535) m_cnt = 65535;
    end
    ef.push_back(m_flags); ec.push_back(m_cnt); ecd.push_back(m_code);
  endtask

  // R12: state after sample k is compared two falling edges after it was driven
  task automatic compare();
    bit [5:0] xf = '0;
    int xc = 0, xd = 0;
    if (ef.size() >= 2) begin
      xf = ef[ef.size()-2]; xc = ec[ec.size()-2]; xd = ecd[ecd.size()-2];
    end
    nchk++;
    if (flags !== xf || vcnt !== 16'(xc) || vcode !== 4'(xd)) begin
      nerr++;
      $display("FAIL %s step %0d: flags %b exp %b cnt %0d exp %0d code %0d exp %0d",
               tag, hist.size(), flags, xf, vcnt, xc, vcode, xd);
    end
  endtask

  task automatic step(input bit c1n, input bit c2, input bit wn, input bit on,
                      input bit dv, input int a, input bit cl);
    vec_t v;
    @(negedge clk);
    compare();
    ce1_n = c1n; ce2 = c2; we_n = wn; oe_n = on; hdrv = dv; clr = cl; addr = AW'(a);
    v.c1n = c1n; v.c2 = c2; v.wn = wn; v.on = on; v.dv = dv; v.cl = cl; v.a = a;
    hist.push_back(v);
    model_push();
  endtask

  task automatic rep(input int n, input bit c1n, input bit c2, input bit wn,
                     input bit on, input bit dv, input int a, input bit cl);
    for (int i = 0; i < n; i++) step(c1n, c2, wn, on, dv, a, cl);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("CHECKS %0d ERRORS %0d", nchk, nerr);
      $finish;
    end
  endtask

  initial begin
    repeat (WD_CYCLES) @(posedge clk);
    nerr++;
    $display("FAIL watchdog: run did not end, actual running expected finished");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state
    nchk++;
    if (flags !== '0 || vcnt !== '0 || vcode !== '0) begin
      nerr++;
      $display("FAIL R1 reset: flags %b cnt %0d code %0d exp 0 0 0", flags, vcnt, vcode);
    end
    rst_n = 1'b1;

    tag = "R1"; rep(3, 1,0,1,1,0, 5, 0);
    // clean write ended by WE rise
    tag = "R2"; rep(6, 0,1,1,1,0, 5, 0); rep(5, 0,1,0,1,1, 5, 0);
    rep(1, 0,1,1,1,0, 5, 0); rep(3, 1,0,1,1,0, 5, 0);
    // short pulse only
    tag = "R2"; rep(6, 0,1,1,1,1, 5, 0); rep(2, 0,1,0,1,1, 5, 0);
    rep(1, 0,1,1,1,0, 5, 0); rep(2, 1,0,1,1,0, 5, 0);
    // select coincides with WE fall, ended by CE1 rise
    tag = "R3"; rep(6, 1,1,1,1,1, 9, 0); rep(5, 0,1,0,1,1, 9, 0);
    rep(1, 1,1,0,1,1, 9, 0); rep(2, 1,1,1,1,0, 9, 0);
    // late data drive
    tag = "R5"; rep(6, 0,1,1,1,0, 9, 0); rep(4, 0,1,0,1,0, 9, 0);
    rep(1, 0,1,0,1,1, 9, 0); rep(1, 0,1,1,1,0, 9, 0); rep(2, 1,0,1,1,0, 9, 0);
    // address moved shortly before write
    tag = "R4"; rep(6, 0,1,1,1,1, 9, 0); rep(1, 0,1,1,1,1, 12, 0);
    rep(4, 0,1,0,1,1, 12, 0); rep(1, 0,1,1,1,0, 12, 0); rep(2, 1,0,1,1,0, 12, 0);
    // clear, then clear with contention in the same sample
    tag = "R11"; rep(1, 1,0,1,1,0, 12, 1); rep(2, 1,0,1,1,0, 12, 0);
    rep(1, 0,1,1,0,1, 12, 1); rep(3, 1,0,1,1,0, 12, 0);
    // end of write and address move in one sample
    tag = "R9"; rep(6, 0,1,1,1,1, 3, 0); rep(2, 0,1,0,1,1, 3, 0);
    rep(1, 0,0,0,1,1, 4, 0); rep(2, 1,0,1,1,0, 4, 0);
    // address move with WE low while deselected
    tag = "R6"; rep(1, 1,0,0,1,0, 4, 0); rep(1, 1,0,0,1,0, 7, 0);
    rep(2, 1,0,1,1,0, 7, 0);
    // contention
    tag = "R7"; rep(1, 1,0,1,1,0, 2, 1); rep(3, 0,1,1,0,1, 2, 0);
    // drive that is not contention
    tag = "R8"; rep(2, 0,1,1,1,1, 2, 0); rep(1, 1,0,1,0,1, 2, 0);
    rep(6, 0,1,0,0,1, 2, 0); rep(1, 1,0,1,0,0, 2, 0); rep(2, 1,0,1,1,0, 2, 0);
    // saturation
    tag = "R10"; rep(1, 1,0,1,1,0, 2, 1); rep(65540, 0,1,1,0,1, 2, 0);
    rep(3, 1,0,1,1,0, 2, 0);
    tag = "R11"; rep(1, 1,0,1,1,0, 2, 1); rep(3, 1,0,1,1,0, 2, 0);
    finish_run();
  end
endmodule